// File: doc/BRIEF.md
# Four-Channel Limit Monitor with Hysteresis

The block checks 12-bit conversion results against a per-channel window. Each of four channels owns an upper bound, a lower bound and a hysteresis amount N. A result arriving on the result input carries a channel tag. If it falls above the upper bound or below the lower bound, the matching bit in a sticky 8-bit status register is set, and the alert output rises. Once a side of a channel has fired, it stays quiet until the result has moved back inside its bound by at least N. This keeps a noisy signal that hovers at a bound from setting the bit over and over.

Loading a channel's hysteresis register with all ones (12 bits) switches that channel into extreme capture. In this mode no limits are checked. The upper-bound register keeps the largest result seen and the lower-bound register keeps the smallest. Software opens a fresh capture window by writing 0 to the upper-bound register and 0xFFF to the lower-bound register. Registers are written and read through a plain address/data port. Reads are combinational on the address.

Top module: `lim_mon`

## Requirements
- R1: After reset every upper-bound register reads 0x0FFF, every lower-bound register reads 0x0000, every hysteresis register reads 0x0008, the status register reads 0x0000 and alert_o is 0.
- R2: Address map. addr_i[4]=1 selects channel register addr_i[3:2], with addr_i[1:0] = 0 for the upper bound, 1 for the lower bound and 2 for hysteresis. Address 0x00 is status and address 0x01 is the clear-control register. Channel registers keep wdata_i[11:0] and read back with bits 15:12 as zero.
- R3: In limit mode, a result on channel c that is greater than the upper bound, while that side is armed, sets status bit 2c+1. The bit is visible on the clock edge that accepts the result.
- R4: In limit mode, a result on channel c that is less than the lower bound, while that side is armed, sets status bit 2c.
- R5: A side that has fired is disarmed. The upper side re-arms on a result with result + N <= upper bound. The lower side re-arms on a result with result >= lower bound + N. While a side is disarmed, a violation does not set its bit.
- R6: Status bits are sticky and accumulate across channels. A write to the status register whose low byte is not 0xFF leaves the status unchanged.
- R7: Two writes clear the status to zero: a write to address 0x00 with wdata_i[7:0]=0xFF, or a write to address 0x01 with wdata_i[2:1]=2'b11. A violation accepted in the same cycle as a clear is kept.
- R8: With hysteresis 0xFFF, a channel sets no status bits. Its upper-bound register takes any result greater than itself, and its lower-bound register takes any result less than itself.
- R9: alert_o is the OR of the eight status bits. It goes high in the cycle after a violating result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address, used for both read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| res_valid_i | input | 1 | Result strobe |
| res_chan_i | input | 2 | Channel tag of the result |
| res_data_i | input | 12 | Conversion result |
| alert_o | output | 1 | OR of status bits |

## Verification
Each result, clear or register write is registered on one edge. A register read is combinational. So every effect is due one cycle after the stimulus. The bench drives inputs on the falling edge and checks status, alert_o and readback on the next falling edge, half a cycle after the registering edge. For alert timing, alert_o is also sampled before the accepting edge, where it must still be low. A bench model tracks the arm state and bounds of each channel and gives the expected status after every result in a sweep over the 12-bit range and over the bound-minus-N edge cases.

// File: rtl/lim_mon_pkg.sv
package lim_mon_pkg;
  localparam logic [1:0] SEL_HI = 2'd0;
  localparam logic [1:0] SEL_LO = 2'd1;
  localparam logic [1:0] SEL_HY = 2'd2;
  localparam int unsigned A_STAT = 0;
  localparam int unsigned A_CFG  = 1;
endpackage

// File: rtl/lim_chan.sv
module lim_chan
  import lim_mon_pkg::*;
#(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned HYST_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              res_vld_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              viol_hi_o,
  output logic              viol_lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hyst_o
);
  logic [DATA_W-1:0] hi_q, lo_q, hyst_q;
  logic arm_hi_q, arm_lo_q;
  logic minmax, above, below, hi_rearm, lo_rearm;

  assign minmax   = &hyst_q;
  assign above    = res_data_i > hi_q;
  assign below    = res_data_i < lo_q;
  // widened by one bit so bound +/- N never wraps
  assign hi_rearm = ({1'b0, res_data_i} + {1'b0, hyst_q}) <= {1'b0, hi_q};
  assign lo_rearm = {1'b0, res_data_i} >= ({1'b0, lo_q} + {1'b0, hyst_q});

  assign viol_hi_o = res_vld_i && !minmax && above && arm_hi_q;
  assign viol_lo_o = res_vld_i && !minmax && below && arm_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_hi_q <= 1'b1;
      arm_lo_q <= 1'b1;
    end else if (res_vld_i && !minmax) begin
      if (above)         arm_hi_q <= 1'b0;
      else if (hi_rearm) arm_hi_q <= 1'b1;
      if (below)         arm_lo_q <= 1'b0;
      else if (lo_rearm) arm_lo_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '1;
      lo_q   <= '0;
      hyst_q <= DATA_W'(HYST_RST);
    end else begin
      if (wr_en_i && wr_sel_i == SEL_HI)    hi_q <= wr_data_i;
      else if (res_vld_i && minmax && above) hi_q <= res_data_i;
      if (wr_en_i && wr_sel_i == SEL_LO)    lo_q <= wr_data_i;
      else if (res_vld_i && minmax && below) lo_q <= res_data_i;
      if (wr_en_i && wr_sel_i == SEL_HY)    hyst_q <= wr_data_i;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign hyst_o = hyst_q;
endmodule

// File: rtl/alert_status.sv
module alert_status #(
  parameter int unsigned ST_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic            clr_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] st_q;

  // new violations survive a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (clr_i ? '0 : st_q) | set_i;
  end

  assign status_o = st_q;
endmodule

// File: rtl/lim_mon.sv
module lim_mon
  import lim_mon_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned HYST_RST = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(NUM_CH)+2:0]  addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  input  logic                       res_valid_i,
  input  logic [$clog2(NUM_CH)-1:0]  res_chan_i,
  input  logic [DATA_W-1:0]          res_data_i,
  output logic                       alert_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam int unsigned AW   = CH_W + 3;
  localparam int unsigned ST_W = 2 * NUM_CH;

  logic            is_chan;
  logic [CH_W-1:0] ch_idx;
  logic [1:0]      sel;
  logic            clr_w;
  logic [ST_W-1:0] set_v, status_q;
  logic [DATA_W-1:0] hi_a [NUM_CH];
  logic [DATA_W-1:0] lo_a [NUM_CH];
  logic [DATA_W-1:0] hy_a [NUM_CH];
  logic unused_wdata;

  assign is_chan = addr_i[AW-1];
  assign ch_idx  = addr_i[CH_W+1:2];
  assign sel     = addr_i[1:0];
  assign unused_wdata = ^wdata_i[REG_W-1:DATA_W];

  assign clr_w = wr_en_i && !is_chan &&
                 ((addr_i == AW'(A_STAT) && (&wdata_i[ST_W-1:0])) ||
                  (addr_i == AW'(A_CFG)  && (&wdata_i[2:1])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_c, vld_c;
    assign wr_c  = wr_en_i && is_chan && ch_idx == CH_W'(c);
    assign vld_c = res_valid_i && res_chan_i == CH_W'(c);
    lim_chan #(.DATA_W(DATA_W), .HYST_RST(HYST_RST)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_c),
      .wr_sel_i   (sel),
      .wr_data_i  (wdata_i[DATA_W-1:0]),
      .res_vld_i  (vld_c),
      .res_data_i (res_data_i),
      .viol_hi_o  (set_v[2*c+1]),
      .viol_lo_o  (set_v[2*c]),
      .hi_o       (hi_a[c]),
      .lo_o       (lo_a[c]),
      .hyst_o     (hy_a[c])
    );
  end

  alert_status #(.ST_W(ST_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_i    (clr_w),
    .status_o (status_q)
  );

  always_comb begin
    rdata_o = '0;
    if (is_chan) begin
      if (int'(ch_idx) < NUM_CH) begin
        unique case (sel)
          SEL_HI:  rdata_o[DATA_W-1:0] = hi_a[ch_idx];
          SEL_LO:  rdata_o[DATA_W-1:0] = lo_a[ch_idx];
          SEL_HY:  rdata_o[DATA_W-1:0] = hy_a[ch_idx];
          default: rdata_o = '0;
        endcase
      end
    end else if (addr_i == AW'(A_STAT)) begin
      rdata_o[ST_W-1:0] = status_q;
    end
  end

  assign alert_o = |status_q;
endmodule

// File: rtl/lim_mon_chk.sv
module lim_mon_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned REG_W  = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [$clog2(NUM_CH)+2:0] addr_i,
  input logic [REG_W-1:0]          rdata_o,
  input logic                      res_valid_i,
  input logic [$clog2(NUM_CH)-1:0] res_chan_i,
  input logic                      alert_o,
  input logic [2*NUM_CH-1:0]       status_q,
  input logic                      clr_w
);
  localparam int unsigned AW   = $clog2(NUM_CH) + 3;
  localparam int unsigned ST_W = 2 * NUM_CH;

  AST_CHAN_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[AW-1] |-> rdata_o[REG_W-1:DATA_W] == '0); // R2

  AST_NEW_BITS_OWN_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ((status_q & ~$past(status_q)) &
      ~({{(ST_W-2){1'b0}}, 2'b11} << (2 * $past(res_chan_i)))) == '0); // R3

  AST_NO_SET_WITHOUT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> (status_q & ~$past(status_q)) == '0); // R4

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_w |=> (status_q & $past(status_q)) == $past(status_q)); // R6

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !res_valid_i) |=> status_q == '0); // R7

  AST_ALERT_RISE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> $past(res_valid_i)); // R9
endmodule

bind lim_mon lim_mon_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .res_valid_i (res_valid_i),
  .res_chan_i  (res_chan_i),
  .alert_o     (alert_o),
  .status_q    (status_q),
  .clr_w       (clr_w)
);

// File: tb/lim_mon_tb.sv
module lim_mon_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        res_valid = 1'b0;
  logic [1:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        alert;

  int n_run = 0, n_fail = 0, cyc = 0;
  int mhi[4], mlo[4], mhy[4];
  bit ahi[4], alo[4];
  logic [7:0] mst;

  always #4 clk = ~clk;

  lim_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .res_valid_i(res_valid),
    .res_chan_i(res_chan), .res_data_i(res_data), .alert_o(alert)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] caddr(int ch, int sel);
    return 5'(16 + ch * 4 + sel);
  endfunction

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, int exp);
    addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic set_chan(int ch, int hi, int lo, int hy);
    wr(caddr(ch, 0), 16'(hi)); mhi[ch] = hi;
    wr(caddr(ch, 1), 16'(lo)); mlo[ch] = lo;
    wr(caddr(ch, 2), 16'(hy)); mhy[ch] = hy;
  endtask

  function automatic void model(int ch, int d);
    if (mhy[ch] == 4095) begin
      if (d > mhi[ch]) mhi[ch] = d;
      if (d < mlo[ch]) mlo[ch] = d;
    end else begin
      if (d > mhi[ch]) begin
        if (ahi[ch]) mst[2*ch+1] = 1'b1;
        ahi[ch] = 1'b0;
      end else if (d + mhy[ch] <= mhi[ch]) ahi[ch] = 1'b1;
      if (d < mlo[ch]) begin
        if (alo[ch]) mst[2*ch] = 1'b1;
        alo[ch] = 1'b0;
      end else if (d >= mlo[ch] + mhy[ch]) alo[ch] = 1'b1;
    end
  endfunction

  task automatic result(int ch, int d, string tag);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 2'(ch); res_data = 12'(d);
    @(negedge clk);
    res_valid = 1'b0;
    model(ch, d);
    rd_chk(tag, 5'd0, int'(mst));
    chk({tag, " R9 alert"}, int'(alert), int'(mst != 0));
  endtask

  task automatic clear_stat(bit use_cfg);
    if (use_cfg) wr(5'd1, 16'h0006);
    else         wr(5'd0, 16'h00FF);
    mst = '0;
    rd_chk("R7 clear", 5'd0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      mhi[c] = 4095; mlo[c] = 0; mhy[c] = 8; ahi[c] = 1; alo[c] = 1;
    end
    mst = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 hi", caddr(c, 0), 'hFFF);
      rd_chk("R1 lo", caddr(c, 1), 0);
      rd_chk("R1 hyst", caddr(c, 2), 8);
    end
    rd_chk("R1 status", 5'd0, 0);
    chk("R1 alert", int'(alert), 0);

    // R2 writes keep 12 bits, upper read as zero
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 3; s++) begin
        wr(caddr(c, s), 16'hF000 | 16'((c * 3 + s) * 291 + 17));
        rd_chk("R2 readback", caddr(c, s), ((c * 3 + s) * 291 + 17) & 'hFFF);
      end
    end

    // sweep: limit mode on every channel
    for (int c = 0; c < 4; c++)
      set_chan(c, 'h900 - c * 'h100, 'h100 + c * 'h40, c * 5 + 1);
    clear_stat(1'b0);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 64; s++) begin
        result(c, (s * 65 + c * 7) % 4096, "R3/R4/R5 sweep");
        if (s % 8 == 7) clear_stat(s % 16 == 15);
      end
    end

    // R5 boundary: upper side of ch0 (hi=0x900, N=1)
    clear_stat(1'b0);
    result(0, 'h100 + 1, "R5 arm");
    result(0, 'h901, "R3 first");
    chk("R3 bit1", int'(mst), 'h02);
    clear_stat(1'b0);
    result(0, 'h901, "R5 disarmed hi");
    chk("R5 no reset", int'(mst), 0);
    result(0, 'h900, "R5 at bound");
    result(0, 'h901, "R5 still disarmed");
    chk("R5 hi still quiet", int'(mst), 0);
    result(0, 'h8FF, "R5 rearm hi");
    result(0, 'h901, "R5 refire hi");
    chk("R5 hi refired", int'(mst), 'h02);
    // lower side of ch1 (lo=0x140, N=6)
    clear_stat(1'b0);
    result(1, 'h400, "R5 arm lo");
    result(1, 'h13F, "R4 first");
    chk("R4 bit2", int'(mst), 'h04);
    clear_stat(1'b1);
    result(1, 'h145, "R5 lo below rearm");
    result(1, 'h13F, "R5 lo quiet");
    chk("R5 lo quiet", int'(mst), 0);
    result(1, 'h146, "R5 lo rearm");
    result(1, 'h13F, "R5 lo refire");
    chk("R5 lo refired", int'(mst), 'h04);

    // R6 sticky across channels, non-FF write ignored
    clear_stat(1'b0);
    result(3, 'hA00, "R6 ch3");
    result(2, 'h500, "R6 ch2 arm");
    result(2, 'h010, "R6 ch2");
    wr(5'd0, 16'h007F);
    rd_chk("R6 partial write ignored", 5'd0, int'(mst));
    wr(5'd1, 16'h0002);
    rd_chk("R6 cfg one bit ignored", 5'd0, int'(mst));

    // R7 clear and violation in the same cycle
    result(0, 'h500, "R7 arm");
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd0; wdata = 16'h00FF;
    res_valid = 1'b1; res_chan = 2'd0; res_data = 12'hFFF;
    @(negedge clk);
    wr_en = 1'b0; res_valid = 1'b0;
    mst = '0; model(0, 'hFFF);
    rd_chk("R7 same-cycle set kept", 5'd0, int'(mst));

    // R8 min/max capture on ch2
    clear_stat(1'b0);
    set_chan(2, 0, 'hFFF, 'hFFF);
    for (int s = 0; s < 40; s++) begin
      result(2, (s * 997 + 300) % 4096, "R8 no status");
      rd_chk("R8 max", caddr(2, 0), mhi[2]);
      rd_chk("R8 min", caddr(2, 1), mlo[2]);
    end

    // R9 alert timing
    clear_stat(1'b0);
    set_chan(2, 'h800, 'h100, 4);
    result(2, 'h400, "R9 arm");
    @(negedge clk);
    res_valid = 1'b1; res_chan = 2'd2; res_data = 12'hFF0;
    #1 chk("R9 alert before edge", int'(alert), 0);
    @(negedge clk);
    res_valid = 1'b0;
    chk("R9 alert after edge", int'(alert), 1);
    model(2, 'hFF0);
    rd_chk("R9 status", 5'd0, int'(mst));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule